// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block produces the basic time slots of a single-wire, open-drain bus master. The four slot types are a bus reset with presence sampling, a write of a 0, a write of a 1, and a read. A controller places one request on the command port. The block drives the shared line low through an output enable for the required time, then releases the line. Where the slot calls for it, the block samples the line through a synchronizer. It ends the slot with a one-cycle done pulse, and the result bit is valid at that point.

All intervals are counted in bus time units. One unit is `CLK_PER_US` clock cycles, which is one microsecond at the intended clock. A run-time integer multiplier stretches every interval of a slot. The multiplier is captured when the slot is accepted. Byte framing, device search and strong pull-up control are left to the controller above this block.

Top module: `owire_slot_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `rx_bit` and `bus_pull_low` are all 0, so the line is released.
- R2: A request (`req_valid` high while `busy` is 0) is accepted at the next clock edge. From that edge `busy` and `bus_pull_low` are 1. `busy` stays high until the edge that raises `done`. `done` is a single-cycle pulse, and it rises at the same edge at which `busy` falls.
- R3: `req_kind`=1 with `req_bit`=1 is a write-1 slot. The line is held low for 6 units and released for 64 units. The slot returns `rx_bit`=0.
- R4: `req_kind`=1 with `req_bit`=0 is a write-0 slot. The line is held low for 60 units and released for 10 units. The slot returns `rx_bit`=0.
- R5: `req_kind`=2 is a read slot. The line is held low for 6 units. The line is then sampled 9 units after release, through a two-stage synchronizer, and `done` follows 55 units after the sample. `rx_bit` is the sampled line level.
- R6: `req_kind`=0 is a bus reset. The line is held low for 500 units and sampled 70 units after release. `done` follows 430 units after the sample. `rx_bit` is 0 when a device held the line low and 1 when no device answered.
- R7: `req_kind`=3 is a touch request. With `req_bit`=1 it behaves exactly as a read slot and returns the sample. With `req_bit`=0 it behaves as a write-0 slot and returns 0, whatever the line level.
- R8: One unit equals `CLK_PER_US` × `delay_mult` clock cycles. `delay_mult` is captured at accept, and a value of 0 counts as 1. Later changes do not affect a slot that is in progress.
- R9: A request presented while `busy` is 1 is ignored. It does not change the current slot's timing or result, and it does not start a slot afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Slot request strobe |
| req_kind | input | 2 | Slot type: 0 reset, 1 write, 2 read, 3 touch |
| req_bit | input | 1 | Data bit for write and touch requests |
| delay_mult | input | MULT_W | Interval stretch factor, 0 treated as 1 |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle slot completion pulse |
| rx_bit | output | 1 | Sampled bit, valid with `done` |
| bus_pull_low | output | 1 | Output enable that pulls the line low |
| bus_in | input | 1 | Raw line level |

## Verification
Each slot type runs with the simulated device either holding the line low or leaving it released. The bench measures both the length of the low pulse and the total busy time, so the read and write-1 slots, which share a 6-unit low phase, are still told apart by the total slot length. The touch requests are compared with both line levels, so a touch with bit 0 cannot be confused with a read. Multipliers of 3 and 0 separate correct stretching and the zero-as-one rule from a fixed unit. A request and a multiplier change made in the middle of a slot show whether the captured settings are really held for the whole slot.

// File: rtl/owire_pkg.sv
package owire_pkg;
  localparam int UNIT_W = 10;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_TOUCH = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_REL  = 2'd2,
    ST_TAIL = 2'd3
  } st_e;

  typedef struct packed {
    logic [UNIT_W-1:0] low;
    logic [UNIT_W-1:0] rel;
    logic [UNIT_W-1:0] tail;
    logic              sample;
  } profile_t;

  function automatic profile_t mk(int lo, int re, int ta, logic smp);
    profile_t p;
    p.low    = UNIT_W'(lo);
    p.rel    = UNIT_W'(re);
    p.tail   = UNIT_W'(ta);
    p.sample = smp;
    return p;
  endfunction

  function automatic profile_t pick_profile(op_e op, logic b);
    profile_t p;
    case (op)
      OP_RESET: p = mk(500, 70, 430, 1'b1);
      OP_WRITE: p = b ? mk(6, 64, 0, 1'b0) : mk(60, 10, 0, 1'b0);
      OP_READ:  p = mk(6, 9, 55, 1'b1);
      default:  p = b ? mk(6, 9, 55, 1'b1) : mk(60, 10, 0, 1'b0);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/owire_unit_timer.sv
module owire_unit_timer #(
  parameter int CLK_PER_US = 125,
  parameter int MULT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [MULT_W-1:0] mult,
  output logic              unit_pulse
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0]     pcnt;
  logic [MULT_W-1:0] mcnt;
  logic              tick;
  logic              m_last;

  assign tick       = run && (pcnt == P_LAST);
  assign m_last     = (mcnt == mult - MULT_W'(1));
  assign unit_pulse = tick && m_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      mcnt <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + PW'(1);
      if (tick) mcnt <= m_last ? '0 : mcnt + MULT_W'(1);
    end
  end
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owire_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int MULT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_bit,
  input  logic [MULT_W-1:0] delay_mult,
  output logic              busy,
  output logic              done,
  output logic              rx_bit,
  output logic              bus_pull_low,
  input  logic              bus_in
);
  st_e               st;
  profile_t          prof;
  logic [MULT_W-1:0] mult_q;
  logic [UNIT_W-1:0] ucnt;
  logic              unit_pulse;
  logic              line_s;
  logic [UNIT_W-1:0] target;

  owire_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .d(bus_in), .q(line_s)
  );

  owire_unit_timer #(.CLK_PER_US(CLK_PER_US), .MULT_W(MULT_W)) i_timer (
    .clk(clk), .rst(rst), .run(st != ST_IDLE), .mult(mult_q),
    .unit_pulse(unit_pulse)
  );

  always_comb begin
    case (st)
      ST_LOW:  target = prof.low;
      ST_REL:  target = prof.rel;
      default: target = prof.tail;
    endcase
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      prof         <= '0;
      mult_q       <= MULT_W'(1);
      ucnt         <= '0;
      done         <= 1'b0;
      rx_bit       <= 1'b0;
      bus_pull_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_valid) begin
          prof         <= pick_profile(op_e'(req_kind), req_bit);
          mult_q       <= (delay_mult == '0) ? MULT_W'(1) : delay_mult;
          ucnt         <= '0;
          st           <= ST_LOW;
          bus_pull_low <= 1'b1;
        end
      end else if (unit_pulse) begin
        if (ucnt != target - UNIT_W'(1)) begin
          ucnt <= ucnt + UNIT_W'(1);
        end else begin
          ucnt <= '0;
          case (st)
            ST_LOW: begin
              st           <= ST_REL;
              bus_pull_low <= 1'b0;
            end
            ST_REL: begin
              rx_bit <= prof.sample ? line_s : 1'b0;
              if (prof.tail == '0) begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end else begin
                st <= ST_TAIL;
              end
            end
            default: begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/owire_slot_checker.sv
module owire_slot_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic bus_pull_low
);
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (busy && bus_pull_low)); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R2
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_pull_low); // R1
  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> (busy || done)); // R9
endmodule

bind owire_slot_engine owire_slot_checker i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .done(done), .bus_pull_low(bus_pull_low)
);

// File: tb/test_owire_slot_engine.sv
module test_owire_slot_engine;
  localparam int N = 2;

  typedef struct {
    int    low;
    int    tot;
    logic  rx;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic       req_bit = 1'b0;
  logic [7:0] delay_mult = 8'd1;
  logic       dev_pull = 1'b0;
  logic       busy, done, rx_bit, bus_pull_low;
  logic       bus_in;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int lowc = 0;
  int totc = 0;
  logic prev_done = 1'b0;

  assign bus_in = !(bus_pull_low || dev_pull);

  always #4 clk = ~clk;

  owire_slot_engine #(.CLK_PER_US(N), .MULT_W(8)) i_owire_slot_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_bit(req_bit), .delay_mult(delay_mult), .busy(busy), .done(done),
    .rx_bit(rx_bit), .bus_pull_low(bus_pull_low), .bus_in(bus_in)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: measures every slot and compares it against the queue head
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_pull_low) lowc++;
      if (busy) totc++;
      if (done) begin
        chk(!prev_done, "R2", "done width", 2, 1);
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected slot", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(lowc == e.low, e.tag, "low cycles", lowc, e.low);
          chk(totc == e.tot, e.tag, "busy cycles", totc, e.tot);
          chk(rx_bit == e.rx, e.tag, "rx_bit", int'(rx_bit), int'(e.rx));
        end
        lowc = 0;
        totc = 0;
      end
      prev_done = done;
    end
  end

  task automatic start(input logic [1:0] kind, input logic b, input logic [7:0] m,
                       input int lo, input int re, input int ta, input logic rx,
                       input string tag);
    exp_t e;
    int mm;
    mm = (m == 0) ? 1 : int'(m);
    e.low = lo * N * mm;
    e.tot = (lo + re + ta) * N * mm;
    e.rx  = rx;
    e.tag = tag;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_kind   = kind;
    req_bit    = b;
    delay_mult = m;
    req_valid  = 1'b1;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && bus_pull_low, "R2", "busy&low after accept",
        int'(busy && bus_pull_low), 1);
  endtask

  task automatic finish_slot();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic slot(input logic [1:0] kind, input logic b, input logic [7:0] m,
                      input int lo, input int re, input int ta, input logic rx,
                      input string tag);
    start(kind, b, m, lo, re, ta, rx, tag);
    finish_slot();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rx_bit && !bus_pull_low, "R1", "reset outputs",
        int'({busy, done, rx_bit, bus_pull_low}), 0);

    dev_pull = 1'b0;
    slot(2'd1, 1'b1, 8'd1, 6, 64, 0, 1'b0, "R3 write1");
    slot(2'd1, 1'b0, 8'd1, 60, 10, 0, 1'b0, "R4 write0");
    slot(2'd2, 1'b0, 8'd1, 6, 9, 55, 1'b1, "R5 read high");
    dev_pull = 1'b1;
    slot(2'd2, 1'b0, 8'd1, 6, 9, 55, 1'b0, "R5 read low");
    slot(2'd0, 1'b0, 8'd1, 500, 70, 430, 1'b0, "R6 reset present");
    dev_pull = 1'b0;
    slot(2'd0, 1'b0, 8'd1, 500, 70, 430, 1'b1, "R6 reset absent");

    slot(2'd3, 1'b1, 8'd1, 6, 9, 55, 1'b1, "R7 touch1 high");
    dev_pull = 1'b1;
    slot(2'd3, 1'b1, 8'd1, 6, 9, 55, 1'b0, "R7 touch1 low");
    dev_pull = 1'b0;
    slot(2'd3, 1'b0, 8'd1, 60, 10, 0, 1'b0, "R7 touch0");

    slot(2'd2, 1'b0, 8'd3, 6, 9, 55, 1'b1, "R8 mult3 read");
    slot(2'd1, 1'b1, 8'd0, 6, 64, 0, 1'b0, "R8 mult0 write1");

    // R9 and R8: mid-slot request and multiplier change are ignored
    start(2'd1, 1'b0, 8'd2, 60, 10, 0, 1'b0, "R9 ignore");
    repeat (30) @(negedge clk);
    req_kind   = 2'd2;
    req_bit    = 1'b1;
    delay_mult = 8'd5;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (5) begin
      @(negedge clk);
      chk(!busy, "R9", "no slot after ignored request", int'(busy), 0);
    end
    chk(q.size() == 0, "R9", "pending items", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL R2 watchdog expired actual=busy expected=idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule